// File: doc/BRIEF.md
# Three-Step Code Lock Controller

This block is a synchronous lock that opens only after three stored code values are entered in order. Each entry is offered on the `key_val` bus and qualified by a one-cycle `key_stb` strobe sampled on the rising clock edge. The design splits into a data path and a control path. The data path holds the three code values, picks one of them with a one-hot selector and compares it with the entered value. The control path is a five-state machine that walks through the three entries and then settles in an open state or an error state.

The state register uses a 4-bit encoding chosen so that the outputs need no decoding. The low three bits are the one-hot selector for the stored code, and the top bit is the unlock output. An error or a completed unlock is cleared only by the synchronous reset. The code values are parameters, and their width is configurable.

Top module: `code_lock`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is the first-entry state. This holds from any state and takes priority over `key_stb` and `key_val`. After it, `sel_oh` = 3'b001 and `unlock` = 0.
- R2: A clock edge with `key_stb` low leaves `sel_oh` and `unlock` unchanged.
- R3: In the first-entry state (`sel_oh` = 001), a strobe with `key_val` == CODE0 moves to the second-entry state (`sel_oh` = 010). In the second-entry state, a strobe with `key_val` == CODE1 moves to the third-entry state (`sel_oh` = 100).
- R4: In the third-entry state, a strobe with `key_val` == CODE2 moves to the open state. There `unlock` = 1 and `sel_oh` = 000.
- R5: In any entry state, a strobe whose value differs from the selected code moves to the error state. There `unlock` = 0 and `sel_oh` = 000.
- R6: The open state and the error state ignore strobes of any value. Only reset leaves them.
- R7: `sel_oh` always equals the low three bits of the state register and is one-hot or zero. `unlock` equals its top bit. The two are never active together.
- R8: `match` is combinational. It is 1 exactly when `key_val` equals the stored code picked by `sel_oh`. It is 0 when `sel_oh` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| key_stb | input | 1 | One-cycle strobe: an entry is present |
| key_val | input | W | Entered code value |
| unlock | output | 1 | 1 = lock open |
| sel_oh | output | 3 | One-hot selector of the stored code under comparison |
| match | output | 1 | Entered value equals the selected code |

## Verification
Any wrong internal state reaches the ports directly, because both `sel_oh` and `unlock` are bits of the state register. A faulty transition therefore shows on the very next sampled cycle after the edge that caused it. A wrong comparison shows at once on `match`, in the same cycle as the stimulus. Its effect on the state shows one edge later as an early unlock, a missed advance or a false error.

// File: rtl/code_lock_pkg.sv
package code_lock_pkg;
    localparam int ST_W = 4;
    typedef enum logic [ST_W-1:0] {
        ST_ERR   = 4'b0000,
        ST_E1    = 4'b0001,
        ST_E2    = 4'b0010,
        ST_E3    = 4'b0100,
        ST_OPEN  = 4'b1000
    } lock_st_e;
endpackage

// File: rtl/code_sel_cmp.sv
module code_sel_cmp #(
    parameter int W = 4,
    parameter int NCODE = 3,
    parameter logic [NCODE*W-1:0] CODES = '0
) (
    input  logic [NCODE-1:0] sel_oh,
    input  logic [W-1:0]     key_val,
    output logic             eq
);
    logic [NCODE-1:0] hit;

    for (genvar g = 0; g < NCODE; g++) begin : g_cmp
        assign hit[g] = sel_oh[g] && (key_val == CODES[g*W +: W]);
    end

    assign eq = |hit;

    // R8: a zero selector never reports a match
    always_comb begin
        if (sel_oh == '0) a_r8_no_sel_no_eq : assert (!eq || $isunknown(sel_oh));
    end
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
    import code_lock_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic key_stb,
    input  logic eq,
    output logic [ST_W-1:0] st
);
    typedef struct packed {
        lock_st_e st;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (rst) begin
            r_d.st = ST_E1;
        end else if (key_stb) begin
            unique case (r_q.st)
                ST_E1:   r_d.st = eq ? ST_E2 : ST_ERR;
                ST_E2:   r_d.st = eq ? ST_E3 : ST_ERR;
                ST_E3:   r_d.st = eq ? ST_OPEN : ST_ERR;
                ST_OPEN: r_d.st = ST_OPEN;
                default: r_d.st = ST_ERR;
            endcase
        end
    end

    always_ff @(posedge clk) r_q <= r_d;

    assign st = r_q.st;

    a_r1_reset_to_first : assert property (@(posedge clk) rst |=> st == ST_E1);
    a_r2_idle_hold : assert property (@(posedge clk) disable iff (rst)
        !key_stb |=> $stable(st));
    a_r6_terminal_sticky : assert property (@(posedge clk) disable iff (rst)
        (st == ST_OPEN || st == ST_ERR) |=> $stable(st));
    a_r5_mismatch_err : assert property (@(posedge clk) disable iff (rst)
        (key_stb && !eq && st != ST_OPEN) |=> st == ST_ERR);
    a_r7_legal_state : assert property (@(posedge clk) disable iff (rst)
        $onehot0(st));
endmodule

// File: rtl/code_lock.sv
module code_lock #(
    parameter int W = 4,
    parameter logic [W-1:0] CODE0 = 4'd3,
    parameter logic [W-1:0] CODE1 = 4'd4,
    parameter logic [W-1:0] CODE2 = 4'd2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         key_stb,
    input  logic [W-1:0] key_val,
    output logic         unlock,
    output logic [2:0]   sel_oh,
    output logic         match
);
    import code_lock_pkg::*;
    localparam int NCODE = 3;

    logic [ST_W-1:0] st;

    code_sel_cmp #(.W(W), .NCODE(NCODE), .CODES({CODE2, CODE1, CODE0})) u_cmp (
        .sel_oh(sel_oh), .key_val(key_val), .eq(match));

    lock_fsm u_fsm (.clk(clk), .rst(rst), .key_stb(key_stb), .eq(match), .st(st));

    assign sel_oh = st[NCODE-1:0];
    assign unlock = st[ST_W-1];

    a_r7_excl : assert property (@(posedge clk) disable iff (rst)
        !(unlock && sel_oh != 3'b000));
    a_r4_open_after_last : assert property (@(posedge clk) disable iff (rst)
        (key_stb && match && sel_oh == 3'b100) |=> unlock);
    a_r3_advance : assert property (@(posedge clk) disable iff (rst)
        (key_stb && match && sel_oh == 3'b001) |=> sel_oh == 3'b010);
endmodule

// File: tb/test_code_lock.sv
module test_code_lock;
    logic clk = 0, rst = 1, key_stb = 0;
    logic [3:0] key_val = 0;
    logic unlock, match;
    logic [2:0] sel_oh;
    int total = 0, bad = 0;
    int m_st = 1; // model: 1,2,3 entry, 4 open, 0 err
    int codes[3] = '{3, 4, 2};

    always #2.5 clk = ~clk;

    code_lock i_code_lock (.clk(clk), .rst(rst), .key_stb(key_stb), .key_val(key_val),
        .unlock(unlock), .sel_oh(sel_oh), .match(match));

    function automatic logic [2:0] exp_sel(int s);
        return (s >= 1 && s <= 3) ? 3'(1 << (s-1)) : 3'b000;
    endfunction

    // model advance at each edge, then compare at negedge
    always @(posedge clk) begin
        if (rst) m_st <= 1;
        else if (key_stb && m_st >= 1 && m_st <= 3)
            m_st <= (key_val == codes[m_st-1]) ? m_st + 1 : 0;
    end

    always @(negedge clk) begin
        logic em;
        em = (m_st >= 1 && m_st <= 3) && (key_val == codes[m_st-1]);
        total++;
        if (sel_oh !== exp_sel(m_st)) begin
            bad++; $display("FAIL R3/R5/R7 sel_oh act=%b exp=%b", sel_oh, exp_sel(m_st));
        end
        total++;
        if (unlock !== (m_st == 4)) begin
            bad++; $display("FAIL R4/R6 unlock act=%b exp=%b", unlock, m_st == 4);
        end
        total++;
        if (match !== em) begin
            bad++; $display("FAIL R8 match act=%b exp=%b", match, em);
        end
    end

    task automatic enter(int v, int idle);
        @(negedge clk); key_val = 4'(v); key_stb = 1;
        @(negedge clk); key_stb = 0;
        for (int i = 0; i < idle; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk); rst = 0;           // R1 reset state
                enter(3, 0); enter(4, 0); enter(2, 2);         // R3 R4 correct
                enter(9, 1); enter(3, 1);                      // R6 open ignores
                do_reset();                                    // R1
                enter(3, 3); enter(4, 5); enter(2, 1);         // R2 idle gaps
                do_reset();
                enter(7, 1); enter(3, 1);                      // R5 first pos
                do_reset();
                enter(3, 0); enter(5, 1); enter(4, 1);         // R5 second pos
                do_reset();
                enter(3, 0); enter(4, 0); enter(4, 1); enter(2, 1); // R5 third
                do_reset();
                enter(3, 0); @(negedge clk); rst = 1; key_stb = 1; key_val = 4;
                @(negedge clk); rst = 0; key_stb = 0;          // R1 priority
                repeat (3) @(negedge clk);
            end
            begin
                repeat (5000) @(negedge clk);
                bad++; total++; $display("FAIL watchdog act=hung exp=done");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule